// File: doc/BRIEF.md
# Scoreboard Hazard Controller

This block is the central hazard controller for a core that issues in order and lets functional units run out of order. It takes one decoded instruction per cycle: a destination register, two source registers and the functional unit the instruction needs. It decides when the instruction may enter that unit, when the unit may fetch its operands and when the unit may store its result. It keeps two tables for this. The first holds one entry per functional unit, with the destination, the sources, the producing unit of each source and a ready flag for each source. The second records, for each architectural register, which unit is due to write it.

Hazards are handled in three places. A write-after-write conflict, or a unit that is already busy, stops issue, and the instruction stays at the input until it is accepted. A read-after-write dependence holds back the operand-read grant until the producing unit has written. A write-after-read conflict holds back the write grant until every older reader has fetched its operands. Functional units raise a done level when they have finished computing. The controller grants one write per cycle by fixed priority. The arithmetic and the register file contents lie outside this block.

Top module: `scoreboard_ctl`

## Requirements
- R1: `in_ready` is high exactly when the unit selected by `in_fu` holds no instruction and no unit is due to write register `in_dst`. An instruction is accepted on a clock edge where `in_valid` and `in_ready` are both high. At most one instruction is accepted per cycle.
- R2: A source is marked ready at issue if no unit is due to write that register. When both sources are ready, the unit's bit in `rd_grant` rises in the cycle after acceptance.
- R3: A source that waits on a producing unit becomes ready on the clock edge where that producer's write is granted. This holds even when the write is granted in the same cycle the reader is accepted. The read grant then rises in the next cycle.
- R4: For each accepted instruction, `rd_grant` for its unit is high for exactly one cycle. The operands are then taken as read, and the unit's ready flags clear.
- R5: The `fu_done` bit of a unit counts as a write request only after that unit's operands have been read. A done level before that has no effect on `wr_grant`.
- R6: A write request is withheld while any other unit still holds an unread, ready source equal to the requester's destination.
- R7: `wr_grant` has at most one bit set. Among eligible requesters, the lowest unit index wins.
- R8: On the edge of a granted write, the unit becomes free and its destination register is released. An instruction that needs either of them can be accepted in the next cycle.
- R9: While reset is asserted, all entries and register owners are cleared, `rd_grant` and `wr_grant` are zero whatever `fu_done` carries, and `in_ready` is high for any in-range unit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded instruction present at the input |
| in_dst | input | REG_W | Destination register |
| in_src1 | input | REG_W | First source register |
| in_src2 | input | REG_W | Second source register |
| in_fu | input | FU_W | Index of the functional unit required |
| in_ready | output | 1 | Instruction may be accepted this cycle |
| fu_done | input | NUM_FU | Per unit: execution finished, result waiting |
| rd_grant | output | NUM_FU | Per unit: fetch operands this cycle |
| wr_grant | output | NUM_FU | Per unit: write result this cycle (one-hot or zero) |

## Verification
The bench builds the block with its default values: three functional units (two multipliers and an adder, by index 0, 1, 2) and sixteen registers. Three units are enough to stage each conflict named in the requirements. One case is a reader that waits on a multiplier while the adder's write is blocked by that same reader, and another is a tie for the write port. Sixteen registers leave room to run scenarios one after another without their register sets overlapping. The two-bit unit index also carries the value 3, which names no unit. This shows that an out-of-range selection never yields `in_ready`.

// File: rtl/sb_pkg.sv
package sb_pkg;
  // Lifecycle of one functional-unit entry
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,  // unit free
    PH_WAIT = 2'd1,  // issued, operands not yet read
    PH_EXEC = 2'd2   // operands read, executing or waiting to write
  } phase_e;
endpackage

// File: rtl/sb_fu_entry.sv
module sb_fu_entry
  import sb_pkg::*;
#(
  parameter int REG_W = 4,
  parameter int FU_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_en,
  input  logic [REG_W-1:0] iss_dst,
  input  logic [REG_W-1:0] iss_s1,
  input  logic [REG_W-1:0] iss_s2,
  input  logic             iss_r1,
  input  logic             iss_r2,
  input  logic [FU_W-1:0]  iss_q1,
  input  logic [FU_W-1:0]  iss_q2,
  input  logic             wr_any,
  input  logic [FU_W-1:0]  wr_fu,
  input  logic             rd_go,
  input  logic             wr_go,
  output logic             busy,
  output logic             exec,
  output logic             rd_req,
  output logic [REG_W-1:0] dst,
  output logic [REG_W-1:0] s1,
  output logic [REG_W-1:0] s2,
  output logic             r1,
  output logic             r2
);
  phase_e           ph_q, ph_d;
  logic [REG_W-1:0] dst_q, dst_d, s1_q, s1_d, s2_q, s2_d;
  logic [FU_W-1:0]  q1_q, q1_d, q2_q, q2_d;
  logic             r1_q, r1_d, r2_q, r2_d;
  logic             upd_en;

  always_comb begin
    ph_d  = ph_q;
    dst_d = dst_q;
    s1_d  = s1_q;
    s2_d  = s2_q;
    q1_d  = q1_q;
    q2_d  = q2_q;
    r1_d  = r1_q;
    r2_d  = r2_q;
    if (issue_en) begin
      ph_d  = PH_WAIT;
      dst_d = iss_dst;
      s1_d  = iss_s1;
      s2_d  = iss_s2;
      r1_d  = iss_r1;
      r2_d  = iss_r2;
      q1_d  = iss_r1 ? '0 : iss_q1;
      q2_d  = iss_r2 ? '0 : iss_q2;
    end else begin
      // producer broadcast: pending sources become ready
      if (ph_q == PH_WAIT && wr_any) begin
        if (!r1_q && q1_q == wr_fu) begin
          r1_d = 1'b1;
          q1_d = '0;
        end
        if (!r2_q && q2_q == wr_fu) begin
          r2_d = 1'b1;
          q2_d = '0;
        end
      end
      if (rd_go) begin
        ph_d = PH_EXEC;
        r1_d = 1'b0;
        r2_d = 1'b0;
      end
      if (wr_go) ph_d = PH_IDLE;
    end
  end

  assign upd_en = issue_en | wr_any | rd_go | wr_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      dst_q <= '0;
      s1_q  <= '0;
      s2_q  <= '0;
      q1_q  <= '0;
      q2_q  <= '0;
      r1_q  <= 1'b0;
      r2_q  <= 1'b0;
    end else if (upd_en) begin
      ph_q  <= ph_d;
      dst_q <= dst_d;
      s1_q  <= s1_d;
      s2_q  <= s2_d;
      q1_q  <= q1_d;
      q2_q  <= q2_d;
      r1_q  <= r1_d;
      r2_q  <= r2_d;
    end
  end

  assign busy   = (ph_q != PH_IDLE);
  assign exec   = (ph_q == PH_EXEC);
  assign rd_req = (ph_q == PH_WAIT) && r1_q && r2_q;
  assign dst    = dst_q;
  assign s1     = s1_q;
  assign s2     = s2_q;
  assign r1     = r1_q && (ph_q == PH_WAIT);
  assign r2     = r2_q && (ph_q == PH_WAIT);

  // R4: operands are fetched once per issued instruction
  a_r4_read_once: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> !rd_req);
  // R5: a write grant only follows an operand read
  a_r5_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> exec);
  // R8: a granted write frees the unit
  a_r8_free_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !issue_en) |=> !busy);
endmodule

// File: rtl/sb_reg_table.sv
module sb_reg_table #(
  parameter int NUM_REGS = 16,
  parameter int REG_W    = 4,
  parameter int FU_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [REG_W-1:0] set_reg,
  input  logic [FU_W-1:0]  set_fu,
  input  logic             clr_en,
  input  logic [REG_W-1:0] clr_reg,
  input  logic [REG_W-1:0] lk_dst,
  input  logic [REG_W-1:0] lk_s1,
  input  logic [REG_W-1:0] lk_s2,
  output logic             dst_owned,
  output logic             s1_owned,
  output logic [FU_W-1:0]  s1_owner,
  output logic             s2_owned,
  output logic [FU_W-1:0]  s2_owner
);
  logic [NUM_REGS-1:0] own_q;
  logic [FU_W-1:0]     who_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic hit_set, hit_clr, own_d;
    assign hit_set = set_en && (set_reg == REG_W'(g));
    assign hit_clr = clr_en && (clr_reg == REG_W'(g));
    always_comb begin
      own_d = own_q[g];
      if (hit_clr) own_d = 1'b0;
      if (hit_set) own_d = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        own_q[g] <= 1'b0;
        who_q[g] <= '0;
      end else begin
        if (hit_set | hit_clr) own_q[g] <= own_d;
        if (hit_set) who_q[g] <= set_fu;
      end
    end
  end

  assign dst_owned = own_q[lk_dst];
  assign s1_owned  = own_q[lk_s1];
  assign s1_owner  = who_q[lk_s1];
  assign s2_owned  = own_q[lk_s2];
  assign s2_owner  = who_q[lk_s2];
endmodule

// File: rtl/sb_wr_arb.sv
module sb_wr_arb #(
  parameter int NUM_FU = 3
) (
  input  logic [NUM_FU-1:0] req,
  output logic [NUM_FU-1:0] gnt
);
  always_comb begin
    logic taken;
    taken = 1'b0;
    gnt   = '0;
    for (int i = 0; i < NUM_FU; i++) begin
      if (req[i] && !taken) begin
        gnt[i] = 1'b1;
        taken  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/scoreboard_ctl.sv
module scoreboard_ctl #(
  parameter int NUM_FU   = 3,
  parameter int NUM_REGS = 16,
  localparam int REG_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int FU_W    = (NUM_FU > 1) ? $clog2(NUM_FU) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [REG_W-1:0]  in_dst,
  input  logic [REG_W-1:0]  in_src1,
  input  logic [REG_W-1:0]  in_src2,
  input  logic [FU_W-1:0]   in_fu,
  output logic              in_ready,
  input  logic [NUM_FU-1:0] fu_done,
  output logic [NUM_FU-1:0] rd_grant,
  output logic [NUM_FU-1:0] wr_grant
);
  logic [NUM_FU-1:0] e_busy, e_exec, e_rdreq, e_r1, e_r2, iss_vec, war_blk, wr_req;
  logic [REG_W-1:0]  e_dst [NUM_FU];
  logic [REG_W-1:0]  e_s1  [NUM_FU];
  logic [REG_W-1:0]  e_s2  [NUM_FU];
  logic              dst_owned, s1_owned, s2_owned, sel_busy, sel_ok;
  logic              wr_any, iss_r1, iss_r2;
  logic [FU_W-1:0]   s1_owner, s2_owner, wr_fu;
  logic [REG_W-1:0]  wr_dst;

  // unit selection and issue decision
  always_comb begin
    sel_busy = 1'b0;
    sel_ok   = 1'b0;
    for (int i = 0; i < NUM_FU; i++) begin
      if (in_fu == FU_W'(i)) begin
        sel_ok   = 1'b1;
        sel_busy = e_busy[i];
      end
    end
  end
  assign in_ready = sel_ok && !sel_busy && !dst_owned;

  always_comb begin
    for (int i = 0; i < NUM_FU; i++)
      iss_vec[i] = in_valid && in_ready && (in_fu == FU_W'(i));
  end

  // write-port encode
  always_comb begin
    wr_fu  = '0;
    wr_dst = '0;
    for (int i = 0; i < NUM_FU; i++) begin
      if (wr_grant[i]) begin
        wr_fu  = FU_W'(i);
        wr_dst = e_dst[i];
      end
    end
  end
  assign wr_any = |wr_grant;

  // a source whose producer writes in this very cycle is ready already
  assign iss_r1 = !s1_owned || (wr_any && s1_owner == wr_fu);
  assign iss_r2 = !s2_owned || (wr_any && s2_owner == wr_fu);

  // write-after-read guard: an older reader still holding a ready copy
  always_comb begin
    for (int i = 0; i < NUM_FU; i++) begin
      war_blk[i] = 1'b0;
      for (int j = 0; j < NUM_FU; j++) begin
        if (j != i && ((e_r1[j] && e_s1[j] == e_dst[i]) ||
                       (e_r2[j] && e_s2[j] == e_dst[i])))
          war_blk[i] = 1'b1;
      end
    end
  end
  assign wr_req   = e_exec & fu_done & ~war_blk;
  assign rd_grant = e_rdreq;

  for (genvar g = 0; g < NUM_FU; g++) begin : g_fu
    sb_fu_entry #(.REG_W(REG_W), .FU_W(FU_W)) u_ent (
      .clk     (clk),
      .rst_n   (rst_n),
      .issue_en(iss_vec[g]),
      .iss_dst (in_dst),
      .iss_s1  (in_src1),
      .iss_s2  (in_src2),
      .iss_r1  (iss_r1),
      .iss_r2  (iss_r2),
      .iss_q1  (s1_owner),
      .iss_q2  (s2_owner),
      .wr_any  (wr_any),
      .wr_fu   (wr_fu),
      .rd_go   (e_rdreq[g]),
      .wr_go   (wr_grant[g]),
      .busy    (e_busy[g]),
      .exec    (e_exec[g]),
      .rd_req  (e_rdreq[g]),
      .dst     (e_dst[g]),
      .s1      (e_s1[g]),
      .s2      (e_s2[g]),
      .r1      (e_r1[g]),
      .r2      (e_r2[g])
    );
  end

  sb_reg_table #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .FU_W(FU_W)) u_rtab (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (in_valid && in_ready),
    .set_reg  (in_dst),
    .set_fu   (in_fu),
    .clr_en   (wr_any),
    .clr_reg  (wr_dst),
    .lk_dst   (in_dst),
    .lk_s1    (in_src1),
    .lk_s2    (in_src2),
    .dst_owned(dst_owned),
    .s1_owned (s1_owned),
    .s1_owner (s1_owner),
    .s2_owned (s2_owned),
    .s2_owner (s2_owner)
  );

  sb_wr_arb #(.NUM_FU(NUM_FU)) u_arb (
    .req(wr_req),
    .gnt(wr_grant)
  );

  // R7: a single write port
  a_r7_one_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_grant));
  // R1: an accepted instruction occupies its unit on the next cycle
  a_r1_issue_occupies: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ((e_busy & $past(iss_vec)) == $past(iss_vec)));
  // R6: no grant to a requester whose destination an older reader still needs
  a_r6_war_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_grant & war_blk) == 0);
endmodule

// File: tb/sim_scoreboard_ctl.sv
module sim_scoreboard_ctl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [3:0] in_dst, in_src1, in_src2;
  logic [1:0] in_fu;
  logic       in_ready;
  logic [2:0] fu_done, rd_grant, wr_grant;
  int         checks = 0;
  int         failures = 0;
  logic       finished = 1'b0;

  always #5 clk = ~clk;

  scoreboard_ctl u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst(in_dst),
    .in_src1(in_src1), .in_src2(in_src2), .in_fu(in_fu), .in_ready(in_ready),
    .fu_done(fu_done), .rd_grant(rd_grant), .wr_grant(wr_grant)
  );

  typedef struct packed {
    logic       v;
    logic [3:0] dst, s1, s2;
    logic [1:0] fu;
    logic [2:0] done;
    logic       rdy;
    logic [2:0] rd, wr;
    logic [3:0] req;
  } vec_t;

  // units: 0 = multiplier A, 1 = multiplier B, 2 = adder
  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'd4, 4'd0,  4'd2,  2'd0, 3'b000, 1'b1, 3'b000, 3'b000, 4'd1}, // R1 issue r4=r0*r2
    '{1'b1, 4'd6, 4'd4,  4'd8,  2'd1, 3'b000, 1'b1, 3'b001, 3'b000, 4'd2}, // R2 read grant next cycle
    '{1'b1, 4'd8, 4'd2,  4'd12, 2'd2, 3'b010, 1'b1, 3'b000, 3'b000, 4'd5}, // R5 done while waiting on RAW
    '{1'b1, 4'd4, 4'd14, 4'd15, 2'd2, 3'b100, 1'b0, 3'b100, 3'b000, 4'd1}, // R1 unit busy + WAW; R5
    '{1'b1, 4'd4, 4'd14, 4'd15, 2'd2, 3'b100, 1'b0, 3'b000, 3'b000, 4'd6}, // R6 adder held by reader of r8
    '{1'b1, 4'd4, 4'd14, 4'd15, 2'd2, 3'b101, 1'b0, 3'b000, 3'b001, 4'd6}, // R6 multiplier A may write
    '{1'b1, 4'd4, 4'd14, 4'd15, 2'd2, 3'b100, 1'b0, 3'b010, 3'b000, 4'd3}, // R3 RAW released
    '{1'b1, 4'd4, 4'd14, 4'd15, 2'd2, 3'b100, 1'b0, 3'b000, 3'b100, 4'd6}, // R6 reader gone, adder writes
    '{1'b1, 4'd4, 4'd14, 4'd15, 2'd2, 3'b000, 1'b1, 3'b000, 3'b000, 4'd8}, // R8 unit and r4 free again
    '{1'b0, 4'd0, 4'd0,  4'd0,  2'd0, 3'b010, 1'b1, 3'b100, 3'b010, 4'd2}, // R2
    '{1'b0, 4'd0, 4'd0,  4'd0,  2'd0, 3'b100, 1'b1, 3'b000, 3'b100, 4'd5}, // R5
    '{1'b1, 4'd1, 4'd3,  4'd3,  2'd0, 3'b000, 1'b1, 3'b000, 3'b000, 4'd1}, // R1
    '{1'b1, 4'd2, 4'd3,  4'd3,  2'd1, 3'b000, 1'b1, 3'b001, 3'b000, 4'd2}, // R2
    '{1'b0, 4'd0, 4'd0,  4'd0,  2'd0, 3'b000, 1'b0, 3'b010, 3'b000, 4'd4}, // R4 single read pulse
    '{1'b0, 4'd0, 4'd0,  4'd0,  2'd0, 3'b011, 1'b0, 3'b000, 3'b001, 4'd7}, // R7 tie: lowest index
    '{1'b0, 4'd0, 4'd0,  4'd0,  2'd0, 3'b010, 1'b1, 3'b000, 3'b010, 4'd7}, // R7 loser next
    '{1'b1, 4'd5, 4'd3,  4'd3,  2'd0, 3'b000, 1'b1, 3'b000, 3'b000, 4'd1}, // R1
    '{1'b1, 4'd5, 4'd3,  4'd3,  2'd1, 3'b000, 1'b0, 3'b001, 3'b000, 4'd1}, // R1 WAW stall
    '{1'b1, 4'd5, 4'd3,  4'd3,  2'd1, 3'b001, 1'b0, 3'b000, 3'b001, 4'd1}, // R1 still held
    '{1'b1, 4'd5, 4'd3,  4'd3,  2'd1, 3'b000, 1'b1, 3'b000, 3'b000, 4'd8}, // R8 r5 released
    '{1'b0, 4'd0, 4'd0,  4'd0,  2'd0, 3'b000, 1'b1, 3'b010, 3'b000, 4'd2}, // R2
    '{1'b0, 4'd0, 4'd0,  4'd0,  2'd0, 3'b010, 1'b1, 3'b000, 3'b010, 4'd5}, // R5
    '{1'b0, 4'd0, 4'd0,  4'd0,  2'd0, 3'b000, 1'b1, 3'b000, 3'b000, 4'd9}, // idle
    '{1'b1, 4'd7, 4'd0,  4'd0,  2'd0, 3'b000, 1'b1, 3'b000, 3'b000, 4'd1}, // R1
    '{1'b0, 4'd0, 4'd0,  4'd0,  2'd2, 3'b000, 1'b1, 3'b001, 3'b000, 4'd2}, // R2
    '{1'b1, 4'd9, 4'd7,  4'd7,  2'd2, 3'b001, 1'b1, 3'b000, 3'b001, 4'd3}, // R3 issue during producer write
    '{1'b0, 4'd0, 4'd0,  4'd0,  2'd0, 3'b000, 1'b1, 3'b100, 3'b000, 4'd3}, // R3 bypass: reads next cycle
    '{1'b0, 4'd0, 4'd0,  4'd0,  2'd0, 3'b100, 1'b1, 3'b000, 3'b100, 4'd5}, // R5
    '{1'b0, 4'd0, 4'd0,  4'd0,  2'd0, 3'b000, 1'b1, 3'b000, 3'b000, 4'd9}  // idle
  };

  task automatic chk(input logic [2:0] act, input logic [2:0] exp,
                     input int req, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [3:0] d, input logic [3:0] a,
                       input logic [3:0] b, input logic [1:0] f, input logic [2:0] dn);
    in_valid = v; in_dst = d; in_src1 = a; in_src2 = b; in_fu = f; fu_done = dn;
  endtask

  initial begin
    rst_n = 1'b0;
    drive(1'b0, 4'd0, 4'd0, 4'd0, 2'd0, 3'b111);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk({2'b00, in_ready}, 3'b001, 9, "in_ready in reset");
    chk(rd_grant, 3'b000, 9, "rd_grant in reset");
    chk(wr_grant, 3'b000, 9, "wr_grant in reset");
    rst_n = 1'b1;
    drive(1'b0, 4'd0, 4'd0, 4'd0, 2'd3, 3'b000);
    #2;
    chk({2'b00, in_ready}, 3'b000, 1, "in_ready for unit index 3");

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(VEC[k].v, VEC[k].dst, VEC[k].s1, VEC[k].s2, VEC[k].fu, VEC[k].done);
      #2;
      chk({2'b00, in_ready}, {2'b00, VEC[k].rdy}, int'(VEC[k].req), $sformatf("in_ready vec %0d", k));
      chk(rd_grant, VEC[k].rd, int'(VEC[k].req), $sformatf("rd_grant vec %0d", k));
      chk(wr_grant, VEC[k].wr, int'(VEC[k].req), $sformatf("wr_grant vec %0d", k));
    end

    // R9: reset while a unit holds an instruction that owns r3
    @(negedge clk);
    drive(1'b1, 4'd3, 4'd1, 4'd1, 2'd0, 3'b000);
    @(negedge clk);
    drive(1'b0, 4'd3, 4'd1, 4'd1, 2'd0, 3'b111);
    #2;
    chk(rd_grant, 3'b001, 2, "rd_grant before reset");
    rst_n = 1'b0;
    #1;
    chk(rd_grant, 3'b000, 9, "rd_grant after reset");
    chk(wr_grant, 3'b000, 9, "wr_grant after reset");
    chk({2'b00, in_ready}, 3'b001, 9, "unit and r3 free after reset");
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, 4'd0, 4'd0, 4'd0, 2'd0, 3'b000);
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R9 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule